// File: doc/BRIEF.md
# DMA Channel Teardown Sequencer

This block holds the per-channel control registers of a packet DMA engine whose channels come in receive/transmit pairs, one pair per port. Each register carries a channel enable, a teardown request, and a default completion queue number. Receive registers also carry a retry-on-starvation flag and a host-descriptor flag. Software writes and reads these registers through a simple synchronous register port.

When software requests teardown on an enabled channel, the sequencer takes a descriptor address from a configurable free queue, using a pop handshake toward the queue manager. A transmit channel may still hold a data descriptor. In that case the sequencer first returns that descriptor to the channel's completion queue. It then pushes the teardown descriptor to the same queue, with its first word encoded as the end-of-channel marker. Software recognises a finished teardown by this in-band descriptor and not by a status bit. Once the marker is accepted, the channel's enable and teardown bits clear and the sequencer is ready for the next request.

Top module: `tdc_top`

## Requirements
- R1: After synchronous reset every channel register and the free-queue register read 0, and neither pop_valid nor push_valid is asserted.
- R2: The receive register of port p sits at 0x808 + 0x20*p and the transmit register at 0x800 + 0x20*p. Bit 31 is enable, bit 30 is teardown, and bits QW-1:0 are the completion queue. Receive registers also keep bit 24 (retry on starvation) and bit 14 (host descriptors). On transmit registers these two bits, and all other unlisted bits, read 0.
- R3: The free-queue register at 0x004 holds the QW-bit queue number used for teardown descriptor pops.
- R4: A teardown bit is accepted only when the channel is already enabled and the same write keeps bit 31 set. Otherwise it reads back 0 and no pop occurs.
- R5: An accepted teardown raises pop_valid with pop_qnum equal to the free-queue number captured when the request was taken up.
- R6: A pop answered with pop_empty=1 is retried: pop_valid stays high until a pop with pop_empty=0 is accepted.
- R7: On a transmit channel whose tx_busy bit is set when the pop succeeds, the in-flight descriptor (the channel's tx_cur_desc slice) is pushed first, with push_is_td=0, to the channel's completion queue.
- R8: The teardown push carries the popped address and the channel's completion queue. Its push_word0 holds 0x13 in bits 31:27, 1 in bit 16 for a receive channel (0 for transmit), the port number in bits 4:0, and 0 in all other bits.
- R9: Receive channels, and idle transmit channels, produce exactly one push (the teardown descriptor); tx_busy never affects a receive channel.
- R10: In the cycle the teardown push is accepted, the channel's enable and teardown bits clear; its other fields keep their values.
- R11: When several teardowns are pending, the lowest slot index is served first. Slot 2p is the receive channel of port p and slot 2p+1 its transmit channel.
- R12: Writes to a channel register whose teardown bit is set are ignored.
- R13: While valid is high and ready is low, pop and push outputs hold valid and keep their queue number and address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 12 | Register read byte address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| tx_busy | input | NUM_CH | Transmit channel p holds an in-flight descriptor |
| tx_cur_desc | input | NUM_CH*32 | In-flight descriptor address of each transmit channel |
| pop_valid | output | 1 | Pop request toward the queue manager |
| pop_qnum | output | QW | Queue to pop from |
| pop_ready | input | 1 | Pop accepted this cycle |
| pop_empty | input | 1 | Popped queue was empty |
| pop_addr | input | 32 | Popped descriptor address |
| push_valid | output | 1 | Push request toward the queue manager |
| push_qnum | output | QW | Queue to push to |
| push_addr | output | 32 | Descriptor address pushed |
| push_is_td | output | 1 | Push carries the teardown descriptor |
| push_word0 | output | 32 | First word of the teardown descriptor |
| push_ready | input | 1 | Push accepted this cycle |

## Verification
The bound checker watches the handshake rules on every cycle: pops and pushes never overlap, requests hold stable while back-pressured, empty pops are retried, a released data descriptor is followed directly by the teardown marker, and every marker carries the teardown type code. Which descriptor is pushed, to which queue, with which port and direction fields, the register readback after completion, the ignored writes and the service order of competing requests can only be shown by the bench's scenarios, which compare them against values it derives itself.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int REG_AW = 12;
    localparam int DESC_W = 32;
    localparam int CQ_MAX = 14;

    localparam logic [4:0]        TD_TYPE    = 5'h13;
    localparam logic [REG_AW-1:0] FREEQ_ADDR = 12'h004;
    localparam logic [REG_AW-1:0] TX_BASE    = 12'h800;
    localparam logic [REG_AW-1:0] RX_BASE    = 12'h808;
    localparam logic [REG_AW-1:0] CH_STRIDE  = 12'h020;

    typedef struct packed {
        logic              en;
        logic              td;
        logic              starv;
        logic              host;
        logic [CQ_MAX-1:0] cq;
    } chan_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_TEAR
    } seq_state_e;

    // even slot = receive channel, odd slot = transmit channel of port idx/2
    function automatic logic [REG_AW-1:0] slot_addr(input int unsigned idx);
        logic [REG_AW-1:0] port;
        port = REG_AW'(idx >> 1);
        return (idx[0] ? TX_BASE : RX_BASE) + port * CH_STRIDE;
    endfunction

    function automatic logic [31:0] td_word0(input logic is_rx, input logic [4:0] port);
        return {TD_TYPE, 10'd0, is_rx, 11'd0, port};
    endfunction

    function automatic logic [31:0] ctrl_image(input chan_ctrl_t c);
        return {c.en, c.td, 5'd0, c.starv, 9'd0, c.host, c.cq};
    endfunction

endpackage

// File: rtl/tdc_regs.sv
module tdc_regs
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int QW     = 8,
    localparam int NSLOT = 2 * NUM_CH,
    localparam int IW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              clr_valid,
    input  logic [IW-1:0]     clr_idx,
    output chan_ctrl_t        ctrl_o [NSLOT],
    output logic [QW-1:0]     free_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '0;
        end else if (wr_en && wr_addr == FREEQ_ADDR) begin
            free_q <= wr_data[QW-1:0];
        end
    end

    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        localparam logic [REG_AW-1:0] ADDR  = slot_addr(j);
        localparam bit                IS_RX = (j % 2) == 0;
        chan_ctrl_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (clr_valid && clr_idx == IW'(j)) begin
                q.en <= 1'b0;
                q.td <= 1'b0;
            end else if (wr_en && wr_addr == ADDR && !q.td) begin
                q.en    <= wr_data[31];
                q.td    <= wr_data[30] & wr_data[31] & q.en;
                q.starv <= IS_RX ? wr_data[24] : 1'b0;
                q.host  <= IS_RX ? wr_data[14] : 1'b0;
                q.cq    <= CQ_MAX'(wr_data[QW-1:0]);
            end
        end

        assign ctrl_o[j] = q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == FREEQ_ADDR) begin
            rd_data = 32'(free_q);
        end
        for (int j = 0; j < NSLOT; j++) begin
            if (rd_addr == slot_addr(j)) begin
                rd_data = ctrl_image(ctrl_o[j]);
            end
        end
    end

endmodule

// File: rtl/tdc_arb.sv
module tdc_arb #(
    parameter int NSLOT = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] pend,
    output logic             pend_any,
    output logic [IW-1:0]    pend_idx
);

    always_comb begin
        pend_any = |pend;
        pend_idx = '0;
        for (int j = NSLOT - 1; j >= 0; j--) begin
            if (pend[j]) begin
                pend_idx = IW'(j);
            end
        end
    end

endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int QW     = 8,
    localparam int NSLOT = 2 * NUM_CH,
    localparam int IW    = $clog2(NSLOT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pend_any,
    input  logic [IW-1:0]            pend_idx,
    input  chan_ctrl_t               ctrl_i [NSLOT],
    input  logic [QW-1:0]            free_q,
    input  logic [NUM_CH-1:0]        tx_busy,
    input  logic [NUM_CH*DESC_W-1:0] tx_cur_desc,
    output logic                     pop_valid,
    output logic [QW-1:0]            pop_qnum,
    input  logic                     pop_ready,
    input  logic                     pop_empty,
    input  logic [DESC_W-1:0]        pop_addr,
    output logic                     push_valid,
    output logic [QW-1:0]            push_qnum,
    output logic [DESC_W-1:0]        push_addr,
    output logic                     push_is_td,
    output logic [31:0]              push_word0,
    input  logic                     push_ready,
    output logic                     clr_valid,
    output logic [IW-1:0]            clr_idx
);

    seq_state_e        state;
    logic [IW-1:0]     sel;
    logic [QW-1:0]     fetch_q;
    logic [DESC_W-1:0] td_addr;
    logic [DESC_W-1:0] data_addr;
    logic [IW-2:0]     sel_port;
    logic              sel_tx;

    assign sel_port = sel[IW-1:1];
    assign sel_tx   = sel[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sel       <= '0;
            fetch_q   <= '0;
            td_addr   <= '0;
            data_addr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend_any) begin
                        sel     <= pend_idx;
                        fetch_q <= free_q;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (pop_ready && !pop_empty) begin
                        td_addr <= pop_addr;
                        if (sel_tx && tx_busy[sel_port]) begin
                            data_addr <= tx_cur_desc[sel_port*DESC_W +: DESC_W];
                            state     <= ST_DATA;
                        end else begin
                            state <= ST_TEAR;
                        end
                    end
                end
                ST_DATA: begin
                    if (push_ready) state <= ST_TEAR;
                end
                ST_TEAR: begin
                    if (push_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pop_valid  = (state == ST_FETCH);
        pop_qnum   = fetch_q;
        push_valid = (state == ST_DATA) || (state == ST_TEAR);
        push_is_td = (state == ST_TEAR);
        push_qnum  = ctrl_i[sel].cq[QW-1:0];
        push_addr  = (state == ST_DATA) ? data_addr : td_addr;
        push_word0 = push_is_td ? td_word0(!sel_tx, 5'(sel_port)) : 32'd0;
        clr_valid  = (state == ST_TEAR) && push_ready;
        clr_idx    = sel;
    end

endmodule

// File: rtl/tdc_top.sv
module tdc_top
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int QW     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr_en,
    input  logic [11:0]              reg_wr_addr,
    input  logic [31:0]              reg_wr_data,
    input  logic [11:0]              reg_rd_addr,
    output logic [31:0]              reg_rd_data,
    input  logic [NUM_CH-1:0]        tx_busy,
    input  logic [NUM_CH*32-1:0]     tx_cur_desc,
    output logic                     pop_valid,
    output logic [QW-1:0]            pop_qnum,
    input  logic                     pop_ready,
    input  logic                     pop_empty,
    input  logic [31:0]              pop_addr,
    output logic                     push_valid,
    output logic [QW-1:0]            push_qnum,
    output logic [31:0]              push_addr,
    output logic                     push_is_td,
    output logic [31:0]              push_word0,
    input  logic                     push_ready
);

    localparam int NSLOT = 2 * NUM_CH;
    localparam int IW    = $clog2(NSLOT);

    chan_ctrl_t        ctrl [NSLOT];
    logic [QW-1:0]     free_q;
    logic [NSLOT-1:0]  pend;
    logic              pend_any;
    logic [IW-1:0]     pend_idx;
    logic              clr_valid;
    logic [IW-1:0]     clr_idx;

    for (genvar j = 0; j < NSLOT; j++) begin : g_pend
        assign pend[j] = ctrl[j].en & ctrl[j].td;
    end

    tdc_regs #(.NUM_CH(NUM_CH), .QW(QW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (reg_rd_addr),
        .rd_data   (reg_rd_data),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .ctrl_o    (ctrl),
        .free_q    (free_q)
    );

    tdc_arb #(.NSLOT(NSLOT)) arb_i (
        .pend     (pend),
        .pend_any (pend_any),
        .pend_idx (pend_idx)
    );

    tdc_seq #(.NUM_CH(NUM_CH), .QW(QW)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .pend_any    (pend_any),
        .pend_idx    (pend_idx),
        .ctrl_i      (ctrl),
        .free_q      (free_q),
        .tx_busy     (tx_busy),
        .tx_cur_desc (tx_cur_desc),
        .pop_valid   (pop_valid),
        .pop_qnum    (pop_qnum),
        .pop_ready   (pop_ready),
        .pop_empty   (pop_empty),
        .pop_addr    (pop_addr),
        .push_valid  (push_valid),
        .push_qnum   (push_qnum),
        .push_addr   (push_addr),
        .push_is_td  (push_is_td),
        .push_word0  (push_word0),
        .push_ready  (push_ready),
        .clr_valid   (clr_valid),
        .clr_idx     (clr_idx)
    );

endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
    parameter int QW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic          pop_empty,
    input logic [QW-1:0] pop_qnum,
    input logic          push_valid,
    input logic          push_ready,
    input logic [QW-1:0] push_qnum,
    input logic [31:0]   push_addr,
    input logic          push_is_td,
    input logic [31:0]   push_word0
);

    AST_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        pop_valid && !pop_ready |=> pop_valid && $stable(pop_qnum)); // R13

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        push_valid && !push_ready |=> push_valid && $stable(push_addr)
                                      && $stable(push_qnum) && $stable(push_is_td)); // R13

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(pop_valid && push_valid)); // R5

    AST_EMPTY_RETRY: assert property (@(posedge clk) disable iff (rst)
        pop_valid && pop_ready && pop_empty |=> pop_valid); // R6

    AST_DATA_THEN_TD: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_ready && !push_is_td |=> push_valid && push_is_td); // R7

    AST_TD_TYPE: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_is_td |-> push_word0[31:27] == 5'h13
                                     && push_word0[26:17] == 10'd0
                                     && push_word0[15:5] == 11'd0); // R8

endmodule

bind tdc_top tdc_checker #(.QW(QW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .pop_empty  (pop_empty),
    .pop_qnum   (pop_qnum),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_qnum  (push_qnum),
    .push_addr  (push_addr),
    .push_is_td (push_is_td),
    .push_word0 (push_word0)
);

// File: tb/tdc_top_tb_top.sv
module tdc_top_tb_top;

    localparam int NUM_CH   = 4;
    localparam int QW       = 8;
    localparam int CLK_HALF = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 reg_wr_en = 1'b0;
    logic [11:0]          reg_wr_addr = '0;
    logic [31:0]          reg_wr_data = '0;
    logic [11:0]          reg_rd_addr = '0;
    logic [31:0]          reg_rd_data;
    logic [NUM_CH-1:0]    tx_busy = '0;
    logic [NUM_CH*32-1:0] tx_cur_desc = '0;
    logic                 pop_valid;
    logic [QW-1:0]        pop_qnum;
    logic                 pop_ready = 1'b0;
    logic                 pop_empty = 1'b0;
    logic [31:0]          pop_addr = '0;
    logic                 push_valid;
    logic [QW-1:0]        push_qnum;
    logic [31:0]          push_addr;
    logic                 push_is_td;
    logic [31:0]          push_word0;
    logic                 push_ready = 1'b0;

    always #CLK_HALF clk = ~clk;

    tdc_top #(.NUM_CH(NUM_CH), .QW(QW)) dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // queue-manager model knobs and logs
    bit          hold_pop = 1'b0;
    bit          hold_push = 1'b0;
    int          empty_left = 0;
    logic [31:0] next_addr = 32'h0001_0000;
    logic [31:0] last_pop = '0;
    int          pop_n = 0;
    int          pop_q_bad = 0;
    logic [QW-1:0] exp_pop_q = '0;
    int          push_n = 0;
    logic [31:0] log_addr [16];
    logic [QW-1:0] log_q  [16];
    logic        log_td   [16];
    logic [31:0] log_w0   [16];

    always @(negedge clk) begin
        pop_ready  = hold_pop ? 1'b0 : (($urandom % 4) != 0);
        pop_empty  = (empty_left > 0);
        pop_addr   = next_addr;
        push_ready = hold_push ? 1'b0 : (($urandom % 3) != 0);
        if (!rst && pop_valid && pop_ready) begin
            pop_n++;
            if (pop_qnum != exp_pop_q) pop_q_bad++;
            if (empty_left > 0) empty_left--;
            else begin
                last_pop  = next_addr;
                next_addr = next_addr + 32'h20;
            end
        end
        if (!rst && push_valid && push_ready && push_n < 16) begin
            log_addr[push_n] = push_addr;
            log_q[push_n]    = push_qnum;
            log_td[push_n]   = push_is_td;
            log_w0[push_n]   = push_word0;
            push_n++;
        end
    end

    function automatic logic [11:0] reg_of(input int port, input bit is_tx);
        return (is_tx ? 12'h800 : 12'h808) + 12'(port * 32);
    endfunction

    function automatic logic [31:0] exp_img(input bit is_tx, input bit en, input bit td,
                                            input bit starv, input bit host, input logic [QW-1:0] cq);
        logic [31:0] v;
        v = 32'(cq);
        v[31] = en;
        v[30] = td;
        if (!is_tx) begin
            v[24] = starv;
            v[14] = host;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_word0(input bit is_tx, input int port);
        logic [31:0] v;
        v = '0;
        v[31:27] = 5'h13;
        v[16] = !is_tx;
        v[4:0] = 5'(port);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic clear_logs();
        pop_n = 0;
        push_n = 0;
        pop_q_bad = 0;
    endtask

    task automatic wait_pushes(input int n);
        for (int k = 0; k < 400 && push_n < n; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit td, input bit starv,
                                              input bit host, input logic [QW-1:0] cq);
        logic [31:0] v;
        v = 32'(cq);
        v[31] = en;
        v[30] = td;
        v[24] = starv;
        v[14] = host;
        v[22] = 1'b1;  // unused bit, must read back 0
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        void'($urandom(32'd7351));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 pop_valid", 32'(pop_valid), 0);
        check("R1 push_valid", 32'(push_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NUM_CH; p++) begin
            reg_read(reg_of(p, 0), rd); check("R1 rx reg", rd, 0);
            reg_read(reg_of(p, 1), rd); check("R1 tx reg", rd, 0);
        end
        reg_read(12'h004, rd); check("R1 free queue", rd, 0);

        // R3: free queue register
        reg_write(12'h004, 32'hFFFF_FF5A);
        reg_read(12'h004, rd); check("R3 free queue", rd, 32'h5A);
        exp_pop_q = 8'h5A;

        // R2: field layout, TX drops rx-only bits
        reg_write(reg_of(2, 0), ctrl_word(1, 0, 1, 1, 8'h3C));
        reg_read(reg_of(2, 0), rd); check("R2 rx image", rd, exp_img(0, 1, 0, 1, 1, 8'h3C));
        reg_write(reg_of(2, 1), ctrl_word(1, 0, 1, 1, 8'hC3));
        reg_read(reg_of(2, 1), rd); check("R2 tx image", rd, exp_img(1, 1, 0, 1, 1, 8'hC3));

        // R4: teardown on a disabled channel is ignored
        clear_logs();
        reg_write(reg_of(1, 1), ctrl_word(0, 0, 0, 0, 8'h11));
        reg_write(reg_of(1, 1), ctrl_word(1, 1, 0, 0, 8'h11));
        repeat (10) @(negedge clk);
        reg_read(reg_of(1, 1), rd); check("R4 td dropped", rd, exp_img(1, 1, 0, 0, 0, 8'h11));
        check("R4 no pop", pop_n, 0);
        // R4: enabled but write clears enable together with teardown
        reg_write(reg_of(1, 1), ctrl_word(0, 1, 0, 0, 8'h11));
        repeat (10) @(negedge clk);
        reg_read(reg_of(1, 1), rd); check("R4 td without en", rd, exp_img(1, 0, 0, 0, 0, 8'h11));
        check("R4 no pop 2", pop_n, 0);
        reg_write(reg_of(2, 0), 32'h0);
        reg_write(reg_of(2, 1), 32'h0);

        // R11 and R12: priority among pending requests, writes ignored while pending
        clear_logs();
        hold_pop = 1'b1;
        reg_write(reg_of(3, 0), ctrl_word(1, 0, 0, 0, 8'h30));
        reg_write(reg_of(1, 0), ctrl_word(1, 0, 0, 0, 8'h10));
        reg_write(reg_of(1, 1), ctrl_word(1, 0, 0, 0, 8'h11));
        reg_write(reg_of(3, 0), ctrl_word(1, 1, 0, 0, 8'h30));
        repeat (3) @(negedge clk);
        reg_write(reg_of(1, 1), ctrl_word(1, 1, 0, 0, 8'h11));
        reg_write(reg_of(1, 0), ctrl_word(1, 1, 0, 0, 8'h10));
        reg_write(reg_of(1, 0), 32'h0000_0077);
        reg_read(reg_of(1, 0), rd); check("R12 write ignored", rd, exp_img(0, 1, 1, 0, 0, 8'h10));
        hold_pop = 1'b0;
        wait_pushes(3);
        check("R11 push count", push_n, 3);
        check("R11 first port3 rx", log_w0[0], exp_word0(0, 3));
        check("R11 second port1 rx", log_w0[1], exp_word0(0, 1));
        check("R11 third port1 tx", log_w0[2], exp_word0(1, 1));
        check("R5 pop queue", pop_q_bad, 0);

        // directed R6: long run of empty responses
        clear_logs();
        empty_left = 5;
        reg_write(reg_of(0, 1), ctrl_word(1, 0, 0, 0, 8'h44));
        reg_write(reg_of(0, 1), ctrl_word(1, 1, 0, 0, 8'h44));
        wait_pushes(1);
        check("R6 pops incl retries", pop_n, 6);
        check("R8 td addr after retry", log_addr[0], last_pop);

        // random teardown scenarios
        for (int it = 0; it < 24; it++) begin
            int p;
            bit is_tx, busy, starv, host;
            logic [QW-1:0] cq;
            int empties, exp_push;
            logic [31:0] cur;
            p = int'($urandom % NUM_CH);
            is_tx = 1'($urandom);
            busy = 1'($urandom);
            starv = 1'($urandom);
            host = 1'($urandom);
            cq = QW'($urandom);
            empties = int'($urandom % 3);
            cur = 32'hA000_0000 + 32'(it) * 32'h40;
            if (it % 6 == 5) begin
                exp_pop_q = QW'($urandom);
                reg_write(12'h004, 32'(exp_pop_q));
            end
            clear_logs();
            tx_busy = '0;
            tx_busy[p] = busy;
            tx_cur_desc[p*32 +: 32] = cur;
            empty_left = empties;
            reg_write(reg_of(p, is_tx), ctrl_word(1, 0, starv, host, cq));
            reg_write(reg_of(p, is_tx), ctrl_word(1, 1, starv, host, cq));
            exp_push = (is_tx && busy) ? 2 : 1;
            wait_pushes(exp_push);
            check("R9 push count", push_n, exp_push);
            check("R6 pop count", pop_n, empties + 1);
            check("R5 pop queue", pop_q_bad, 0);
            if (exp_push == 2) begin
                check("R7 data addr", log_addr[0], cur);
                check("R7 data queue", 32'(log_q[0]), 32'(cq));
                check("R7 data flag", 32'(log_td[0]), 0);
            end
            check("R8 td addr", log_addr[exp_push-1], last_pop);
            check("R8 td queue", 32'(log_q[exp_push-1]), 32'(cq));
            check("R8 td flag", 32'(log_td[exp_push-1]), 1);
            check("R8 word0", log_w0[exp_push-1], exp_word0(is_tx, p));
            reg_read(reg_of(p, is_tx), rd);
            check("R10 readback", rd, exp_img(is_tx, 0, 0, starv, host, cq));
            tx_busy = '0;
        end

        check("R13 idle after run", 32'(pop_valid | push_valid), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule